// File: doc/BRIEF.md
# Dual-Path Buffered Memory Arbiter

This block sits between two independent requesters and a two-ported, banked system memory. One requester is the processor and the other is the master of the expansion bus. Each has its own request/grant handshake and its own 16-byte write-gathering buffer. Partial writes that stay inside one aligned 16-byte block are merged byte by byte and do not use memory at all. A block is committed as one packet when it is complete, when the path moves to another block, or on an explicit flush. Reads look into both buffers so that bytes not yet written to memory are still returned.

Both paths can run in the same cycle as long as their memory cycles fall in different banks. A clash on the same bank is settled by a priority bit that alternates between the paths. A mode input selects single-path operation. In that mode the bus master owns memory whenever it is active, and the processor waits.

The memory side is one port per path. Each port carries a block address, a 16-lane byte enable and 128-bit write data, and it takes back the addressed 128-bit block in the same cycle.

Top module: `dpa_dual_arb`

## Requirements
- R1: In dual mode a request that needs no memory cycle is granted in the cycle it is presented, with no memory enable. A buffered write that stays in the current block and leaves it incomplete is such a request. A memory read is granted only together with a memory read on the same path.
- R2: With buffering on, writes to one 16-byte block merge per byte lane. The write that makes all 16 lanes valid is committed in that cycle as a single memory write with byte enable 16'hFFFF, and the buffer empties.
- R3: With buffering off, every granted write is its own memory write. It enables only the four lanes of its word (word index = address bits [3:2]), masked by its byte enables.
- R4: When both paths need memory and their banks differ, both are granted in the same cycle. The bank is the low NBB bits of the block address, which for the default is address bit 4.
- R5: A bus-master I/O request (io flag high) never uses memory and is granted at once. The processor keeps full use of memory in that cycle.
- R6: When both paths need the same bank in dual mode, only one is served. The first such clash after reset goes to the bus master, and each later clash goes to the path that lost the previous one.
- R7: In single-path mode the processor gets no grant and no memory cycle while the bus master requests or is flushing. The bus master is always granted.
- R8: A buffered write to a block other than the one held commits the held bytes (old block address, old byte enables) in that cycle. The buffer then holds only the new write.
- R9: A flush pulse marks each non-empty buffer. A marked buffer commits its bytes on a later cycle in which its path has no memory request and wins memory.
- R10: Read data takes each byte from the path's own buffer if that buffer holds the byte for that block. Otherwise it takes the byte from the other path's buffer. Otherwise it comes from memory.
- R11: After reset both buffers are empty, the priority favours the bus master, and with no requests there are no grants and no memory enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_i | input | 1 | 1 = overlapped dual-path mode, 0 = single-path mode |
| buf_en_i | input | 1 | 1 = gather writes, 0 = one memory write per word (change only when buffers are empty) |
| flush_i | input | 1 | Pulse that marks non-empty buffers for commit |
| c_req_i | input | 1 | Processor request |
| c_we_i | input | 1 | Processor write (1) or read (0) |
| c_addr_i | input | AW-2 | Processor word address (byte address bits AW-1:2) |
| c_wdata_i | input | 32 | Processor write data |
| c_be_i | input | 4 | Processor byte enables |
| c_gnt_o | output | 1 | Processor grant |
| c_rdata_o | output | 32 | Processor read data, valid with a read grant |
| b_req_i | input | 1 | Bus-master request |
| b_io_i | input | 1 | Bus-master request is an I/O cycle |
| b_we_i | input | 1 | Bus-master write (1) or read (0) |
| b_addr_i | input | AW-2 | Bus-master word address |
| b_wdata_i | input | 32 | Bus-master write data |
| b_be_i | input | 4 | Bus-master byte enables |
| b_gnt_o | output | 1 | Bus-master grant |
| b_rdata_o | output | 32 | Bus-master read data |
| c_mem_en_o | output | 1 | Processor-path memory cycle |
| c_mem_we_o | output | 1 | Processor-path memory write |
| c_mem_blk_o | output | AW-4 | Processor-path block address |
| c_mem_wdata_o | output | 128 | Processor-path packet data |
| c_mem_be_o | output | 16 | Processor-path packet byte enables |
| c_mem_rdata_i | input | 128 | Block read from memory for the processor path |
| b_mem_en_o | output | 1 | Bus-master-path memory cycle |
| b_mem_we_o | output | 1 | Bus-master-path memory write |
| b_mem_blk_o | output | AW-4 | Bus-master-path block address |
| b_mem_wdata_o | output | 128 | Bus-master-path packet data |
| b_mem_be_o | output | 16 | Bus-master-path packet byte enables |
| b_mem_rdata_i | input | 128 | Block read from memory for the bus-master path |

## Verification
The bench reads, from the bus master, a word whose bytes are held only in the processor's buffer. A design that ignored the other buffer would return stale memory bytes there. It flushes both buffers while they hold blocks in the same bank, and then sends repeated clashing reads. A fixed-priority arbiter would serve the same path twice in a row, and one that got the alternation wrong would let the wrong path win the first clash. It also covers filling a block from split partial writes, switching to a new block with a partial buffer still held, and single-path mode with an I/O cycle running. A wrong lane merge would show up as a wrong packet or wrong byte enables. A leaky single-path gate would show up as a processor grant while the bus master is active.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_RD, OP_WR1, OP_SWAP, OP_FULL, OP_GATHER, OP_FLUSH
  } buf_op_e;

  // own buffer bytes win over the other path's, which win over memory
  function automatic logic [31:0] pick_word(input logic [127:0] mem,
                                            input logic [127:0] own_d,
                                            input logic [127:0] oth_d,
                                            input logic [15:0]  own_be,
                                            input logic [15:0]  oth_be,
                                            input logic [1:0]   w);
    logic [31:0] r;
    int i;
    for (int k = 0; k < 4; k++) begin
      i = 4 * int'(w) + k;
      if (own_be[i])      r[8*k +: 8] = own_d[8*i +: 8];
      else if (oth_be[i]) r[8*k +: 8] = oth_d[8*i +: 8];
      else                r[8*k +: 8] = mem[8*i +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/dpa_wbuf.sv
`timescale 1ns/1ps
module dpa_wbuf import dpa_pkg::*; #(
  parameter int AW = 16,
  localparam int BW = AW - 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           buf_en_i,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:2]  addr_i,
  input  logic [31:0]    wdata_i,
  input  logic [3:0]     be_i,
  input  logic           flush_i,
  input  logic           go_i,
  output logic           need_o,
  output logic           need_we_o,
  output logic [BW-1:0]  need_blk_o,
  output logic [127:0]   need_data_o,
  output logic [15:0]    need_be_o,
  output logic           hold_o,
  output logic [BW-1:0]  hold_blk_o,
  output logic [127:0]   hold_data_o,
  output logic [15:0]    hold_be_o
);
  logic           vld_q, pend_q, vld_n;
  logic [BW-1:0]  blk_q, blk_n;
  logic [127:0]   dat_q, dat_n;
  logic [15:0]    be_q, be_n;

  logic [BW-1:0]  blk;
  logic [1:0]     w;
  logic           hit;
  logic [15:0]    ins_be, mrg_be;
  logic [127:0]   ins_data, mrg_data;
  buf_op_e        op;

  assign blk      = addr_i[AW-1:4];
  assign w        = addr_i[3:2];
  assign hit      = vld_q && (blk_q == blk);
  assign ins_be   = {12'b0, be_i} << (4 * w);
  assign ins_data = {96'b0, wdata_i} << (32 * w);
  assign mrg_be   = (hit ? be_q : 16'b0) | ins_be;

  for (genvar k = 0; k < 16; k++) begin : g_lane
    assign mrg_data[8*k +: 8] = ins_be[k] ? ins_data[8*k +: 8] : dat_q[8*k +: 8];
  end

  always_comb begin
    if (req_i && !we_i)              op = OP_RD;
    else if (req_i && !buf_en_i)     op = OP_WR1;
    else if (req_i && vld_q && !hit) op = OP_SWAP;
    else if (req_i && (&mrg_be))     op = OP_FULL;
    else if (req_i)                  op = OP_GATHER;
    else if (pend_q && vld_q)        op = OP_FLUSH;
    else                             op = OP_NONE;
  end

  always_comb begin
    need_o      = 1'b1;
    need_we_o   = 1'b1;
    need_blk_o  = blk;
    need_data_o = dat_q;
    need_be_o   = be_q;
    unique case (op)
      OP_RD:     begin need_we_o = 1'b0; need_be_o = 16'b0; end
      OP_WR1:    begin need_data_o = ins_data; need_be_o = ins_be; end
      OP_SWAP:   need_blk_o = blk_q;
      OP_FLUSH:  need_blk_o = blk_q;
      OP_FULL:   begin need_data_o = mrg_data; need_be_o = 16'hFFFF; end
      default:   begin need_o = 1'b0; need_we_o = 1'b0; end
    endcase
  end

  always_comb begin
    vld_n = vld_q;
    blk_n = blk_q;
    dat_n = dat_q;
    be_n  = be_q;
    if (go_i) begin
      unique case (op)
        OP_SWAP:   begin vld_n = 1'b1; blk_n = blk; dat_n = ins_data; be_n = ins_be; end
        OP_GATHER: begin vld_n = 1'b1; blk_n = blk; dat_n = mrg_data; be_n = mrg_be; end
        OP_FULL, OP_FLUSH: begin vld_n = 1'b0; be_n = 16'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      blk_q  <= '0;
      dat_q  <= '0;
      be_q   <= '0;
    end else begin
      vld_q  <= vld_n;
      pend_q <= (pend_q | flush_i) & vld_n;
      blk_q  <= blk_n;
      dat_q  <= dat_n;
      be_q   <= be_n;
    end
  end

  assign hold_o      = vld_q;
  assign hold_blk_o  = blk_q;
  assign hold_data_o = dat_q;
  assign hold_be_o   = be_q;
endmodule

// File: rtl/dpa_arb.sv
`timescale 1ns/1ps
module dpa_arb #(
  parameter int NBB = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dual_i,
  input  logic           c_act_i,
  input  logic           c_need_i,
  input  logic [NBB-1:0] c_bank_i,
  input  logic           b_act_i,
  input  logic           b_need_i,
  input  logic [NBB-1:0] b_bank_i,
  output logic           c_go_o,
  output logic           b_go_o
);
  logic prio_c_q, clash;

  assign clash = dual_i && c_need_i && b_need_i && (c_bank_i == b_bank_i);

  always_comb begin
    if (dual_i) begin
      c_go_o = c_act_i && !(clash && !prio_c_q);
      b_go_o = b_act_i && !(clash && prio_c_q);
    end else begin
      // single path: processor parks while the bus master is active
      b_go_o = b_act_i;
      c_go_o = c_act_i && !b_act_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prio_c_q <= 1'b0;
    else if (clash) prio_c_q <= ~prio_c_q;
  end
endmodule

// File: rtl/dpa_dual_arb.sv
`timescale 1ns/1ps
module dpa_dual_arb import dpa_pkg::*; #(
  parameter int AW  = 16,
  parameter int NBB = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dual_i,
  input  logic             buf_en_i,
  input  logic             flush_i,
  input  logic             c_req_i,
  input  logic             c_we_i,
  input  logic [AW-1:2]    c_addr_i,
  input  logic [31:0]      c_wdata_i,
  input  logic [3:0]       c_be_i,
  output logic             c_gnt_o,
  output logic [31:0]      c_rdata_o,
  input  logic             b_req_i,
  input  logic             b_io_i,
  input  logic             b_we_i,
  input  logic [AW-1:2]    b_addr_i,
  input  logic [31:0]      b_wdata_i,
  input  logic [3:0]       b_be_i,
  output logic             b_gnt_o,
  output logic [31:0]      b_rdata_o,
  output logic             c_mem_en_o,
  output logic             c_mem_we_o,
  output logic [AW-5:0]    c_mem_blk_o,
  output logic [127:0]     c_mem_wdata_o,
  output logic [15:0]      c_mem_be_o,
  input  logic [127:0]     c_mem_rdata_i,
  output logic             b_mem_en_o,
  output logic             b_mem_we_o,
  output logic [AW-5:0]    b_mem_blk_o,
  output logic [127:0]     b_mem_wdata_o,
  output logic [15:0]      b_mem_be_o,
  input  logic [127:0]     b_mem_rdata_i
);
  localparam int BW = AW - 4;

  logic           mreq [2];
  logic           we   [2];
  logic [AW-1:2]  addr [2];
  logic [31:0]    wdat [2];
  logic [3:0]     be   [2];
  logic [127:0]   mrd  [2];
  logic           go   [2];
  logic           need [2];
  logic           nwe  [2];
  logic [BW-1:0]  nblk [2];
  logic [127:0]   ndat [2];
  logic [15:0]    nbe  [2];
  logic           hld  [2];
  logic [BW-1:0]  hblk [2];
  logic [127:0]   hdat [2];
  logic [15:0]    hbe  [2];
  logic [31:0]    rdat [2];

  assign mreq[0] = c_req_i;
  assign mreq[1] = b_req_i & ~b_io_i;
  assign we[0]   = c_we_i;    assign we[1]   = b_we_i;
  assign addr[0] = c_addr_i;  assign addr[1] = b_addr_i;
  assign wdat[0] = c_wdata_i; assign wdat[1] = b_wdata_i;
  assign be[0]   = c_be_i;    assign be[1]   = b_be_i;
  assign mrd[0]  = c_mem_rdata_i;
  assign mrd[1]  = b_mem_rdata_i;

  for (genvar g = 0; g < 2; g++) begin : g_path
    localparam int O = 1 - g;
    logic own_hit, oth_hit;

    dpa_wbuf #(.AW(AW)) u_buf (
      .clk_i, .rst_ni, .buf_en_i,
      .req_i(mreq[g]), .we_i(we[g]), .addr_i(addr[g]),
      .wdata_i(wdat[g]), .be_i(be[g]), .flush_i, .go_i(go[g]),
      .need_o(need[g]), .need_we_o(nwe[g]), .need_blk_o(nblk[g]),
      .need_data_o(ndat[g]), .need_be_o(nbe[g]),
      .hold_o(hld[g]), .hold_blk_o(hblk[g]), .hold_data_o(hdat[g]),
      .hold_be_o(hbe[g])
    );

    assign own_hit = hld[g] && (hblk[g] == addr[g][AW-1:4]);
    assign oth_hit = hld[O] && (hblk[O] == addr[g][AW-1:4]);
    assign rdat[g] = pick_word(mrd[g], hdat[g], hdat[O],
                               own_hit ? hbe[g] : 16'b0,
                               oth_hit ? hbe[O] : 16'b0,
                               addr[g][3:2]);
  end

  dpa_arb #(.NBB(NBB)) u_arb (
    .clk_i, .rst_ni, .dual_i,
    .c_act_i(c_req_i | need[0]), .c_need_i(need[0]), .c_bank_i(nblk[0][NBB-1:0]),
    .b_act_i(b_req_i | need[1]), .b_need_i(need[1]), .b_bank_i(nblk[1][NBB-1:0]),
    .c_go_o(go[0]), .b_go_o(go[1])
  );

  assign c_gnt_o       = c_req_i & go[0];
  assign b_gnt_o       = b_req_i & (b_io_i | go[1]);
  assign c_rdata_o     = rdat[0];
  assign b_rdata_o     = rdat[1];

  assign c_mem_en_o    = go[0] & need[0];
  assign c_mem_we_o    = nwe[0];
  assign c_mem_blk_o   = nblk[0];
  assign c_mem_wdata_o = ndat[0];
  assign c_mem_be_o    = nbe[0];
  assign b_mem_en_o    = go[1] & need[1];
  assign b_mem_we_o    = nwe[1];
  assign b_mem_blk_o   = nblk[1];
  assign b_mem_wdata_o = ndat[1];
  assign b_mem_be_o    = nbe[1];
endmodule

// File: rtl/dpa_dual_arb_chk.sv
`timescale 1ns/1ps
module dpa_dual_arb_chk #(
  parameter int AW  = 16,
  parameter int NBB = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dual_i,
  input logic          buf_en_i,
  input logic          c_req_i,
  input logic          c_we_i,
  input logic          c_gnt_o,
  input logic          b_req_i,
  input logic          b_io_i,
  input logic          b_gnt_o,
  input logic          c_mem_en_o,
  input logic          c_mem_we_o,
  input logic [AW-5:0] c_mem_blk_o,
  input logic [15:0]   c_mem_be_o,
  input logic          b_mem_en_o,
  input logic [AW-5:0] b_mem_blk_o
);
  a_r6_bank_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i && c_mem_en_o && b_mem_en_o |-> c_mem_blk_o[NBB-1:0] != b_mem_blk_o[NBB-1:0]);

  a_r7_single_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_i && b_req_i |-> !c_gnt_o && !c_mem_en_o && b_gnt_o);

  a_r5_io_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dual_i && b_req_i && b_io_i |-> b_gnt_o);

  a_r3_word_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_i && c_req_i && c_we_i && c_gnt_o |->
      c_mem_en_o && c_mem_we_o && ($countones(c_mem_be_o) <= 4));

  a_r1_read_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_mem_en_o && !c_mem_we_o |-> c_req_i && !c_we_i && c_gnt_o);
endmodule

bind dpa_dual_arb dpa_dual_arb_chk #(.AW(AW), .NBB(NBB)) u_chk (.*);

// File: tb/dpa_dual_arb_test.sv
`timescale 1ns/1ps
module dpa_dual_arb_test;
  localparam int AW = 8;
  localparam int NBB = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic dual_i, buf_en_i, flush_i, io;
  logic rq [2];
  logic wq [2];
  logic [7:0]  ad [2];
  logic [31:0] wd [2];
  logic [3:0]  bq [2];

  logic c_gnt_o, b_gnt_o, c_mem_en_o, b_mem_en_o, c_mem_we_o, b_mem_we_o;
  logic [31:0]  c_rdata_o, b_rdata_o;
  logic [3:0]   c_mem_blk_o, b_mem_blk_o;
  logic [127:0] c_mem_wdata_o, b_mem_wdata_o, c_mem_rdata_i, b_mem_rdata_i;
  logic [15:0]  c_mem_be_o, b_mem_be_o;

  bit [7:0] mem [256];

  always_comb begin
    for (int i = 0; i < 16; i++) begin
      c_mem_rdata_i[8*i +: 8] = mem[{c_mem_blk_o, 4'(i)}];
      b_mem_rdata_i[8*i +: 8] = mem[{b_mem_blk_o, 4'(i)}];
    end
  end

  dpa_dual_arb #(.AW(AW), .NBB(NBB)) uut (
    .clk_i(clk), .rst_ni, .dual_i, .buf_en_i, .flush_i,
    .c_req_i(rq[0]), .c_we_i(wq[0]), .c_addr_i(ad[0][7:2]), .c_wdata_i(wd[0]),
    .c_be_i(bq[0]), .c_gnt_o, .c_rdata_o,
    .b_req_i(rq[1]), .b_io_i(io), .b_we_i(wq[1]), .b_addr_i(ad[1][7:2]),
    .b_wdata_i(wd[1]), .b_be_i(bq[1]), .b_gnt_o, .b_rdata_o,
    .c_mem_en_o, .c_mem_we_o, .c_mem_blk_o, .c_mem_wdata_o, .c_mem_be_o, .c_mem_rdata_i,
    .b_mem_en_o, .b_mem_we_o, .b_mem_blk_o, .b_mem_wdata_o, .b_mem_be_o, .b_mem_rdata_i
  );

  int errors = 0;
  int checks = 0;

  // reference state
  bit       mv [2];
  bit [3:0] mblk [2];
  bit [7:0] md [2][16];
  bit       mbe [2][16];
  bit       mpend [2];
  bit       mprio;
  // per-cycle reference results
  int       op [2];
  bit       need [2], nwe [2], ngo [2], gnt_e [2];
  bit [3:0] nb [2];
  bit [7:0] nd [2][16];
  bit       nbe [2][16];
  bit [7:0] ins_d [2][16], mg_d [2][16];
  bit       ins_b [2][16], mg_b [2][16];
  bit       clash;

  task automatic chk(string tag, string what, logic [127:0] a, logic [127:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, a, e);
    end
  endtask

  task automatic model_eval();
    for (int p = 0; p < 2; p++) begin
      bit mr, hit, full;
      bit [3:0] bk;
      int w;
      mr = rq[p] && !(p == 1 && io);
      bk = ad[p][7:4];
      w  = int'(ad[p][3:2]);
      hit = mv[p] && mblk[p] == bk;
      full = 1'b1;
      for (int i = 0; i < 16; i++) begin
        ins_b[p][i] = (i / 4 == w) && bq[p][i % 4];
        ins_d[p][i] = wd[p][8*(i%4) +: 8];
        mg_b[p][i]  = (hit && mbe[p][i]) || ins_b[p][i];
        mg_d[p][i]  = ins_b[p][i] ? ins_d[p][i] : md[p][i];
        full &= mg_b[p][i];
      end
      if (mr && !wq[p])              op[p] = 1;
      else if (mr && !buf_en_i)      op[p] = 2;
      else if (mr && mv[p] && !hit)  op[p] = 3;
      else if (mr && full)           op[p] = 4;
      else if (mr)                   op[p] = 5;
      else if (mpend[p] && mv[p])    op[p] = 6;
      else                           op[p] = 0;
      need[p] = op[p] inside {1, 2, 3, 4, 6};
      nwe[p]  = op[p] != 1;
      nb[p]   = (op[p] == 3 || op[p] == 6) ? mblk[p] : bk;
      for (int i = 0; i < 16; i++) begin
        case (op[p])
          2: begin nd[p][i] = ins_d[p][i]; nbe[p][i] = ins_b[p][i]; end
          3, 6: begin nd[p][i] = md[p][i]; nbe[p][i] = mbe[p][i]; end
          4: begin nd[p][i] = mg_d[p][i]; nbe[p][i] = 1'b1; end
          default: begin nd[p][i] = 8'h0; nbe[p][i] = 1'b0; end
        endcase
      end
    end
    clash = dual_i && need[0] && need[1] && nb[0][0] == nb[1][0];
    if (dual_i) begin
      ngo[0] = (rq[0] || need[0]) && !(clash && !mprio);
      ngo[1] = (rq[1] || need[1]) && !(clash && mprio);
    end else begin
      ngo[1] = rq[1] || need[1];
      ngo[0] = (rq[0] || need[0]) && !ngo[1];
    end
    gnt_e[0] = rq[0] && ngo[0];
    gnt_e[1] = rq[1] && (io || ngo[1]);
  endtask

  function automatic logic [31:0] exp_rd(int p);
    logic [31:0] r;
    int o, i;
    bit [3:0] bk;
    o = 1 - p;
    bk = ad[p][7:4];
    for (int k = 0; k < 4; k++) begin
      i = 4 * int'(ad[p][3:2]) + k;
      if (mv[p] && mblk[p] == bk && mbe[p][i])      r[8*k +: 8] = md[p][i];
      else if (mv[o] && mblk[o] == bk && mbe[o][i]) r[8*k +: 8] = md[o][i];
      else                                          r[8*k +: 8] = mem[{bk, 4'(i)}];
    end
    return r;
  endfunction

  task automatic compare(string tag);
    logic         a_en, a_we;
    logic [3:0]   a_blk;
    logic [15:0]  a_be, e_be;
    logic [127:0] a_d, e_d, msk;
    chk(tag, "c_gnt", 128'(c_gnt_o), 128'(gnt_e[0]));
    chk(tag, "b_gnt", 128'(b_gnt_o), 128'(gnt_e[1]));
    for (int p = 0; p < 2; p++) begin
      a_en  = p == 0 ? c_mem_en_o : b_mem_en_o;
      a_we  = p == 0 ? c_mem_we_o : b_mem_we_o;
      a_blk = p == 0 ? c_mem_blk_o : b_mem_blk_o;
      a_be  = p == 0 ? c_mem_be_o : b_mem_be_o;
      a_d   = p == 0 ? c_mem_wdata_o : b_mem_wdata_o;
      chk(tag, p == 0 ? "c_mem_en" : "b_mem_en", 128'(a_en), 128'(ngo[p] && need[p]));
      if (ngo[p] && need[p]) begin
        for (int i = 0; i < 16; i++) begin
          e_be[i] = nbe[p][i];
          e_d[8*i +: 8] = nd[p][i];
          msk[8*i +: 8] = {8{nbe[p][i]}};
        end
        chk(tag, "mem_we", 128'(a_we), 128'(nwe[p]));
        chk(tag, "mem_blk", 128'(a_blk), 128'(nb[p]));
        if (nwe[p]) begin
          chk(tag, "mem_be", 128'(a_be), 128'(e_be));
          chk(tag, "mem_wdata", a_d & msk, e_d & msk);
        end
      end
      if (gnt_e[p] && !wq[p] && !(p == 1 && io))
        chk(tag, "rdata", 128'(p == 0 ? c_rdata_o : b_rdata_o), 128'(exp_rd(p)));
    end
  endtask

  task automatic model_commit();
    for (int p = 0; p < 2; p++) begin
      if (ngo[p] && need[p] && nwe[p])
        for (int i = 0; i < 16; i++)
          if (nbe[p][i]) mem[{nb[p], 4'(i)}] = nd[p][i];
      if (ngo[p]) begin
        case (op[p])
          3: begin mv[p] = 1; mblk[p] = ad[p][7:4];
                   for (int i = 0; i < 16; i++) begin mbe[p][i] = ins_b[p][i]; md[p][i] = ins_d[p][i]; end end
          5: begin mv[p] = 1; mblk[p] = ad[p][7:4];
                   for (int i = 0; i < 16; i++) begin mbe[p][i] = mg_b[p][i]; md[p][i] = mg_d[p][i]; end end
          4, 6: begin mv[p] = 0; for (int i = 0; i < 16; i++) mbe[p][i] = 0; end
          default: ;
        endcase
      end
      mpend[p] = (mpend[p] | flush_i) & mv[p];
    end
    if (clash) mprio = !mprio;
  endtask

  task automatic step(string tag);
    #1;
    model_eval();
    compare(tag);
    @(posedge clk);
    model_commit();
    @(negedge clk);
  endtask

  task automatic idle();
    rq[0] = 0; rq[1] = 0; io = 0; flush_i = 0;
  endtask

  task automatic put(int p, bit w, logic [7:0] a, logic [31:0] d, logic [3:0] b);
    rq[p] = 1; wq[p] = w; ad[p] = a; wd[p] = d; bq[p] = b;
  endtask

  initial begin
    dual_i = 1; buf_en_i = 1; idle();
    for (int p = 0; p < 2; p++) begin
      wq[p] = 0; ad[p] = 0; wd[p] = 0; bq[p] = 0;
      mv[p] = 0; mpend[p] = 0;
    end
    mprio = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R11: reset state
    step("R11");
    chk("R11", "c_mem_en idle", 128'(c_mem_en_o), 128'(0));

    // R1 / R2: gather a block from split partial writes
    put(0, 1, 8'h00, 32'h11223344, 4'hF); step("R1");
    put(0, 1, 8'h04, 32'h55667788, 4'h3); step("R1");
    put(0, 1, 8'h04, 32'h99AABBCC, 4'hC); step("R2");
    put(0, 1, 8'h08, 32'hDDEEFF00, 4'hF); step("R2");
    put(0, 1, 8'h0C, 32'h0BADF00D, 4'hF); step("R2");
    put(0, 0, 8'h04, 0, 0); step("R10");

    // R10: bus-master read sees processor-buffered bytes
    idle(); put(0, 1, 8'h24, 32'hAABBCCDD, 4'h5); step("R1");
    idle(); put(1, 0, 8'h24, 0, 0); step("R10");
    idle(); put(0, 0, 8'h24, 0, 0); step("R10");

    // R8: switch block with a partial buffer held
    idle(); put(0, 1, 8'h34, 32'hC0FFEE11, 4'hF); step("R8");
    idle(); put(1, 1, 8'h50, 32'h12345678, 4'h6); step("R1");

    // R9 + R6: flush two buffers in the same bank
    idle(); flush_i = 1; step("R9");
    idle(); step("R9");
    step("R9");
    step("R9");

    // R4: different banks together
    put(0, 0, 8'h30, 0, 0); put(1, 0, 8'h04, 0, 0); step("R4");
    idle(); put(0, 0, 8'h00, 0, 0); put(1, 0, 8'h54, 0, 0); step("R4");

    // R6: repeated clashes alternate
    put(0, 0, 8'h00, 0, 0); put(1, 0, 8'h20, 0, 0);
    step("R6"); step("R6"); step("R6"); step("R6");

    // R5: I/O cycle beside a processor read
    idle(); put(0, 0, 8'h20, 0, 0); put(1, 0, 8'h20, 0, 0); io = 1; step("R5");

    // R7: single-path mode
    dual_i = 0;
    idle(); put(0, 0, 8'h00, 0, 0); put(1, 0, 8'h10, 0, 0); step("R7");
    io = 1; step("R7");
    idle(); put(0, 0, 8'h00, 0, 0); step("R7");
    dual_i = 1;

    // R3: unbuffered writes
    idle(); buf_en_i = 0;
    put(0, 1, 8'h44, 32'hFACE0FF1, 4'h6); put(1, 1, 8'h58, 32'h76543210, 4'hF); step("R3");
    idle(); put(0, 1, 8'h48, 32'h01020304, 4'h9); step("R3");
    idle(); put(0, 0, 8'h44, 0, 0); put(1, 0, 8'h58, 0, 0); step("R3");
    buf_en_i = 1;

    // R2 on the bus-master path
    idle();
    put(1, 1, 8'h60, 32'hA1A2A3A4, 4'hF); step("R2");
    put(1, 1, 8'h64, 32'hB1B2B3B4, 4'hF); step("R2");
    put(1, 1, 8'h68, 32'hC1C2C3C4, 4'hF); step("R2");
    put(1, 1, 8'h6C, 32'hD1D2D3D4, 4'hF); step("R2");
    put(1, 0, 8'h64, 0, 0); step("R2");
    idle(); step("R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule